// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block chooses the strength code for a memory device's output drivers. It receives a digitized measurement of an external reference resistor, in ohms, and a flag that is set when the calibration pin is tied to the supply. The target driver impedance is one fifth of the reference resistance. The block turns that target into a 6-bit strength code and hands it to the driver. At reset it starts from a fixed default code, so the driver is usable before the first measurement has been taken.

A free-running interval timer takes a new sample on a fixed period. This tracks slow supply and temperature drift. A new code is held in a pending register. It reaches the active driver register only in a cycle where the output is not driving data, so no data beat ever mixes two codes. Reads and writes are never stalled. A separate settling counter raises a ready flag once the settling window after reset has run out. Traffic is allowed before that point, but the impedance is not yet guaranteed to be optimal.

Top module: `zq_cal_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `drv_code` is 36 (the code for 50 ohms), `cal_ready` is 0 and `code_load` is 0.
- R2: For a reference value r in 175..350 ohms, the target code is floor((70 - floor(r/5)) * 63 / 35). Code 0 is the weakest driver and 63 the strongest.
- R3: A reference value below 175 is treated as 175, which gives code 63. A value above 350 is treated as 350, which gives code 0.
- R4: While `zq_tied_high` is 1, the sampled target is 63 whatever the value on `rq_ohms`.
- R5: The inputs are sampled only on the clock edges numbered k*RESAMPLE_INTERVAL after reset release (k = 1, 2, ...). A change that is withdrawn before the next such edge has no effect.
- R6: The active code changes only on an edge where `out_busy` is 0. A pending code waits for as long as `out_busy` stays high, and it is applied on the first edge with `out_busy` low.
- R7: `code_load` is high for exactly the one cycle after each edge where `drv_code` took a different value. A sample that gives the current code produces no load.
- R8: `cal_ready` becomes 1 right after the SETTLE_CYCLES-th edge after reset release, and it stays 1 until reset.
- R9: If a pending code is applied on a sampling edge, the new sample is compared against the code being applied. A different target is loaded on the following idle edge. An equal target causes no second load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rq_ohms | input | RES_W (10) | Measured reference resistance in ohms |
| zq_tied_high | input | 1 | Calibration pin strapped to supply: force the strongest code |
| out_busy | input | 1 | Output is driving data this cycle |
| drv_code | output | CODE_W (6) | Active driver strength code |
| code_load | output | 1 | One-cycle pulse after the active code has changed |
| cal_ready | output | 1 | Settling window has elapsed |

## Verification
Two functions can land on the same edge: the periodic sample and the transfer of a pending code into the active register. The bench holds `out_busy` high so that a code stays pending. It then changes the resistance and releases `out_busy` one cycle before a sampling edge, so that the transfer and the new sample coincide. The result is judged at the ports over the next two cycles. The bench checks that the first code is applied, then that the second follows one edge later, and also checks the variant where the new sample equals the code being applied and must not produce a second `code_load`.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;
  localparam int unsigned ZQ_CODE_W_DEF = 6;
  localparam int unsigned ZQ_RES_W_DEF  = 10;
  localparam int unsigned ZQ_R_LO_DEF   = 175;
  localparam int unsigned ZQ_R_HI_DEF   = 350;
  localparam int unsigned ZQ_RATIO_DEF  = 5;
  localparam int unsigned ZQ_Z_BOOT_DEF = 50;

  // Linear map: highest impedance -> code 0, lowest impedance -> cmax.
  function automatic int unsigned zq_code_of(input int unsigned z,
                                             input int unsigned zlo,
                                             input int unsigned zhi,
                                             input int unsigned cmax);
    if (z >= zhi) return 0;
    if (z <= zlo) return cmax;
    return ((zhi - z) * cmax) / (zhi - zlo);
  endfunction
endpackage

// File: rtl/zq_code_map.sv
module zq_code_map
  import zq_cal_pkg::*;
#(
  parameter int unsigned RES_W  = ZQ_RES_W_DEF,
  parameter int unsigned CODE_W = ZQ_CODE_W_DEF,
  parameter int unsigned R_LO   = ZQ_R_LO_DEF,
  parameter int unsigned R_HI   = ZQ_R_HI_DEF,
  parameter int unsigned RATIO  = ZQ_RATIO_DEF
) (
  input  logic [RES_W-1:0]  rq_ohms,
  input  logic              strap,
  output logic [CODE_W-1:0] target
);
  localparam int unsigned Z_LO  = R_LO / RATIO;
  localparam int unsigned Z_HI  = R_HI / RATIO;
  localparam int unsigned C_MAX = (1 << CODE_W) - 1;

  int unsigned       r_raw;
  int unsigned       r_clamped;
  int unsigned       z_target;
  logic [CODE_W-1:0] c_lin;

  always_comb begin
    r_raw = {{(32-RES_W){1'b0}}, rq_ohms};
    if (r_raw < R_LO)      r_clamped = R_LO;
    else if (r_raw > R_HI) r_clamped = R_HI;
    else                   r_clamped = r_raw;
    z_target = r_clamped / RATIO;
    c_lin    = CODE_W'(zq_code_of(z_target, Z_LO, Z_HI, C_MAX));
    target   = strap ? {CODE_W{1'b1}} : c_lin;
  end
endmodule

// File: rtl/zq_cal_timer.sv
module zq_cal_timer #(
  parameter int unsigned INTERVAL = 64,
  parameter int unsigned SETTLE   = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic cal_ready
);
  localparam int unsigned IV_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int unsigned ST_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  logic [IV_W-1:0] iv_cnt;
  logic [ST_W-1:0] st_cnt;

  assign tick = (iv_cnt == IV_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_cnt    <= '0;
      st_cnt    <= '0;
      cal_ready <= 1'b0;
    end else begin
      iv_cnt <= tick ? '0 : iv_cnt + 1'b1;
      if (!cal_ready) begin
        st_cnt <= st_cnt + 1'b1;
        if (st_cnt == ST_W'(SETTLE - 1)) cal_ready <= 1'b1;
      end
    end
  end

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cal_ready |=> cal_ready);
endmodule

// File: rtl/zq_code_apply.sv
module zq_code_apply #(
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned BOOT_CODE = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  input  logic              out_busy,
  output logic [CODE_W-1:0] drv_code,
  output logic              code_load
);
  logic [CODE_W-1:0] pend_code;
  logic              pend_vld;
  logic              apply;
  logic [CODE_W-1:0] eff_code;

  assign apply    = pend_vld & ~out_busy;
  assign eff_code = apply ? pend_code : drv_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_code  <= CODE_W'(BOOT_CODE);
      pend_code <= CODE_W'(BOOT_CODE);
      pend_vld  <= 1'b0;
      code_load <= 1'b0;
    end else begin
      code_load <= apply;
      if (apply) drv_code <= pend_code;
      if (tick) begin
        pend_code <= target;
        pend_vld  <= (target != eff_code);
      end else if (apply) begin
        pend_vld <= 1'b0;
      end
    end
  end

  assert_idle_only_R6: assert property (@(posedge clk) disable iff (rst)
    code_load |-> !$past(out_busy));
  assert_load_changes_R7: assert property (@(posedge clk) disable iff (rst)
    code_load |-> (drv_code != $past(drv_code)));
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!code_load && !$past(rst)) |-> (drv_code == $past(drv_code)));
endmodule

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl
  import zq_cal_pkg::*;
#(
  parameter int unsigned CODE_W            = ZQ_CODE_W_DEF,
  parameter int unsigned RES_W             = ZQ_RES_W_DEF,
  parameter int unsigned R_LO              = ZQ_R_LO_DEF,
  parameter int unsigned R_HI              = ZQ_R_HI_DEF,
  parameter int unsigned RATIO             = ZQ_RATIO_DEF,
  parameter int unsigned Z_BOOT            = ZQ_Z_BOOT_DEF,
  parameter int unsigned RESAMPLE_INTERVAL = 64,
  parameter int unsigned SETTLE_CYCLES     = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RES_W-1:0]  rq_ohms,
  input  logic              zq_tied_high,
  input  logic              out_busy,
  output logic [CODE_W-1:0] drv_code,
  output logic              code_load,
  output logic              cal_ready
);
  localparam int unsigned BOOT_CODE =
    zq_code_of(Z_BOOT, R_LO / RATIO, R_HI / RATIO, (1 << CODE_W) - 1);

  logic              tick;
  logic [CODE_W-1:0] target;

  zq_cal_timer #(
    .INTERVAL (RESAMPLE_INTERVAL),
    .SETTLE   (SETTLE_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cal_ready (cal_ready)
  );

  zq_code_map #(
    .RES_W  (RES_W),
    .CODE_W (CODE_W),
    .R_LO   (R_LO),
    .R_HI   (R_HI),
    .RATIO  (RATIO)
  ) u_map (
    .rq_ohms (rq_ohms),
    .strap   (zq_tied_high),
    .target  (target)
  );

  zq_code_apply #(
    .CODE_W    (CODE_W),
    .BOOT_CODE (BOOT_CODE)
  ) u_apply (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .target    (target),
    .out_busy  (out_busy),
    .drv_code  (drv_code),
    .code_load (code_load)
  );
endmodule

// File: tb/test_zq_cal_ctrl.sv
module test_zq_cal_ctrl;
  localparam int IV = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] rq_ohms;
  logic       zq_tied_high;
  logic       out_busy;
  logic [5:0] drv_code;
  logic       code_load;
  logic       cal_ready;

  int total = 0;
  int bad   = 0;
  int ecount;
  int loads = 0;

  always #10 clk = ~clk;

  zq_cal_ctrl #(.RESAMPLE_INTERVAL(IV)) i_zq_cal_ctrl (
    .clk(clk), .rst(rst), .rq_ohms(rq_ohms), .zq_tied_high(zq_tied_high),
    .out_busy(out_busy), .drv_code(drv_code), .code_load(code_load),
    .cal_ready(cal_ready)
  );

  always @(posedge clk) if (rst) ecount <= 0; else ecount <= ecount + 1;
  always @(negedge clk) if (!rst && code_load) loads++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int r, input bit strap);
    int rc;
    if (strap) return 63;
    rc = (r < 175) ? 175 : (r > 350) ? 350 : r;
    return ((70 - rc / 5) * 63) / 35;
  endfunction

  task automatic to_phase(input int p);
    do @(negedge clk); while ((ecount % IV) != p);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int prev;
    int nchg;
    int l0;
    rst = 1'b1; rq_ohms = 10'd250; zq_tied_high = 1'b0; out_busy = 1'b0;
    repeat (4) @(negedge clk);
    chk(drv_code == 36, "R1 code", drv_code, 36);
    chk(cal_ready == 0, "R1 ready", cal_ready, 0);
    chk(code_load == 0, "R1 load", code_load, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(drv_code == 36 && code_load == 0, "R1 after release", drv_code, 36);

    while (ecount < 1023) @(negedge clk);
    chk(cal_ready == 0, "R8 before window", cal_ready, 0);
    @(negedge clk);
    chk(cal_ready == 1, "R8 at window", cal_ready, 1);
    chk(loads == 0, "R7 identical samples", loads, 0);
    chk(drv_code == 36, "R7 code kept", drv_code, 36);

    // R2/R3 sweep
    to_phase(1);
    prev = 36; nchg = 0; l0 = loads;
    for (int r = 150; r <= 400; r++) begin
      rq_ohms = 10'(r);
      repeat (IV) @(negedge clk);
      chk(drv_code == exp_code(r, 0), (r < 175 || r > 350) ? "R3 clamp" : "R2 map",
          drv_code, exp_code(r, 0));
      if (exp_code(r, 0) != prev) nchg++;
      prev = exp_code(r, 0);
    end
    chk(loads - l0 == nchg, "R7 load count", loads - l0, nchg);
    rq_ohms = 10'd0;
    repeat (IV) @(negedge clk);
    chk(drv_code == 63, "R3 zero", drv_code, 63);
    rq_ohms = 10'd1023;
    repeat (IV) @(negedge clk);
    chk(drv_code == 0, "R3 max input", drv_code, 0);

    // R5 sampling instant
    rq_ohms = 10'd200;
    to_phase(0);
    chk(drv_code == 0, "R5 before sample", drv_code, 0);
    @(negedge clk);
    chk(drv_code == 54, "R5 after sample", drv_code, 54);
    chk(code_load == 1, "R7 pulse", code_load, 1);
    @(negedge clk);
    chk(code_load == 0, "R7 single pulse", code_load, 0);
    l0 = loads;
    to_phase(1);
    rq_ohms = 10'd300;
    to_phase(5);
    rq_ohms = 10'd200;
    to_phase(2);
    chk(drv_code == 54 && loads == l0, "R5 withdrawn change", drv_code, 54);

    // R6 busy hold
    out_busy = 1'b1;
    rq_ohms = 10'd330;
    l0 = loads;
    repeat (3 * IV) @(negedge clk);
    chk(drv_code == 54, "R6 held while busy", drv_code, 54);
    chk(loads == l0, "R6 no load while busy", loads - l0, 0);
    to_phase(5);
    out_busy = 1'b0;
    @(negedge clk);
    chk(drv_code == 7, "R6 applied when idle", drv_code, 7);
    chk(code_load == 1, "R6 load pulse", code_load, 1);

    // R4 strap
    zq_tied_high = 1'b1;
    rq_ohms = 10'd200;
    to_phase(1);
    repeat (IV) @(negedge clk);
    chk(drv_code == 63, "R4 strap", drv_code, 63);
    l0 = loads;
    rq_ohms = 10'd1023;
    repeat (IV) @(negedge clk);
    chk(drv_code == 63 && loads == l0, "R4 sample ignored", drv_code, 63);
    zq_tied_high = 1'b0;
    repeat (IV) @(negedge clk);
    chk(drv_code == 0, "R4 strap removed", drv_code, 0);

    // R9 apply and sample on the same edge, different target
    out_busy = 1'b1;
    rq_ohms = 10'd250;
    to_phase(1); to_phase(1);
    rq_ohms = 10'd175;
    to_phase(IV - 1);
    out_busy = 1'b0;
    @(negedge clk);
    chk(drv_code == 36 && code_load == 1, "R9 first apply", drv_code, 36);
    @(negedge clk);
    chk(drv_code == 63 && code_load == 1, "R9 second apply", drv_code, 63);
    @(negedge clk);
    chk(code_load == 0, "R9 settled", code_load, 0);

    // R9 variant: equal target
    out_busy = 1'b1;
    rq_ohms = 10'd330;
    to_phase(1); to_phase(1);
    rq_ohms = 10'd331;
    to_phase(IV - 1);
    out_busy = 1'b0;
    @(negedge clk);
    chk(drv_code == 7 && code_load == 1, "R9 equal apply", drv_code, 7);
    @(negedge clk);
    chk(drv_code == 7 && code_load == 0, "R9 no second load", code_load, 0);

    chk(cal_ready == 1, "R8 sticky", cal_ready, 1);
    finish_run();
  end
endmodule